// File: doc/BRIEF.md
# Clock Host Register Port with Interrupt Flags

This block is the host-facing side of a real-time clock. The host first writes a register index through an address port, then reads or writes the selected register through a data port. The index stays latched, so repeated data-port accesses keep hitting the same register. Behind the index sit the time and alarm bytes, two control registers (called A and B here), two status registers (C and D) and a block of general-purpose storage bytes.

The time counter is outside this block. It signals the end of each update and the periodic tick as one-cycle event pulses, and it reports its update-busy state as a level. The block turns these events into sticky flags in register C. On each update-end event it also compares the seconds, minutes and hours bytes with their alarm bytes. It derives an interrupt-pending summary from the flags that are enabled in register B and drives an active-low interrupt request. Reading register C returns its value and then clears the flags, which releases the interrupt.

Top module: `rtcr_host_regs`

## Requirements
- R1: A data-port write (`bus_wr`=1, `bus_addr_sel`=0) or read (`bus_rd`=1, `bus_addr_sel`=0) targets the index that was last written through the address port (`bus_wr`=1, `bus_addr_sel`=1). The index is unchanged by every other access.
- R2: Indexes 0x00 to 0x09 and 0x0E to 0x3F are plain byte storage that reads back the last value written. Indexes 0x40 and above read 0x00, and writes to them have no effect.
- R3: Register A sits at index 0x0A. Its bit 7 reads the `upd_busy` input, and host writes to that bit are ignored. Bits 6:0 read back the last value written.
- R4: Register B sits at index 0x0B and reads back all 8 bits as written. Bit 4 enables the update-end interrupt, bit 5 the alarm interrupt and bit 6 the periodic interrupt.
- R5: In register C (index 0x0C), an `upd_done_evt` pulse sets bit 4 and a `periodic_evt` pulse sets bit 6, whatever the enables in register B. Bits 3:0 of register C always read 0.
- R6: On an `upd_done_evt` pulse, register C bit 5 (alarm) is set when three pairs all match: index 0x00 with 0x01 (seconds), 0x02 with 0x03 (minutes) and 0x04 with 0x05 (hours). An alarm byte (0x01, 0x03 or 0x05) whose bits 7:6 are both 1 matches any value.
- R7: Register C bit 7 is 1 exactly when some flag in bits 6:4 is set and the register B bit in the same position is also 1. `irq_n` is 0 exactly while that summary bit is 1.
- R8: A data-port read of register C returns its current value, and all its flags are 0 from the next cycle on. An event pulse in the same cycle as that read still sets its flag.
- R9: Register D (index 0x0D) reads 0x80. Host writes to registers C and D have no effect.
- R10: After reset, the index is 0x00, registers A and B and all storage bytes are 0x00, register C is 0x00 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr_sel | input | 1 | 1 selects the address port, 0 the data port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe for the data port, one cycle per access |
| bus_wdata | input | 8 | Write data or index |
| bus_rdata | output | 8 | Contents of the register selected by the current index |
| upd_done_evt | input | 1 | One-cycle pulse when a time update finishes |
| periodic_evt | input | 1 | One-cycle pulse at the periodic rate |
| upd_busy | input | 1 | Level: time update in progress |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The checker assumes that the host never raises a read and a write strobe in the same cycle, and that `bus_rd` only matters on the data port. The flag properties assume that the event pulses come only from the counter and that anything can happen alongside them. The random stimulus drives at most one host strobe per cycle, and it raises event pulses and the busy level freely, including in the same cycle as a read of register C. Writes to the time and alarm bytes are drawn from a small value set that includes wildcard alarm bytes, so alarm matches, misses and wildcard hits all occur often.

// File: rtl/rtcr_pkg.sv
package rtcr_pkg;

    // fixed control/status indexes
    localparam logic [7:0] IDX_CTL_A  = 8'h0A;
    localparam logic [7:0] IDX_CTL_B  = 8'h0B;
    localparam logic [7:0] IDX_STAT_C = 8'h0C;
    localparam logic [7:0] IDX_STAT_D = 8'h0D;

    // time / alarm byte positions inside the time block
    localparam int TOD_SEC  = 0;
    localparam int TOD_ASEC = 1;
    localparam int TOD_MIN  = 2;
    localparam int TOD_AMIN = 3;
    localparam int TOD_HR   = 4;
    localparam int TOD_AHR  = 5;

    // flag vector positions (register C bits 4,5,6)
    localparam int FLG_UPD = 0;
    localparam int FLG_ALM = 1;
    localparam int FLG_PER = 2;
    localparam int NUM_FLG = 3;

    localparam logic [1:0] ALARM_ANY = 2'b11;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TOD,
        SEL_CA,
        SEL_CB,
        SEL_SC,
        SEL_SD,
        SEL_RAM
    } sel_e;

endpackage

// File: rtl/rtcr_index_decode.sv
module rtcr_index_decode
    import rtcr_pkg::*;
#(
    parameter int DW        = 8,
    parameter int TOD_REGS  = 10,
    parameter int RAM_BASE  = 14,
    parameter int RAM_BYTES = 50,
    localparam int TOD_AW   = $clog2(TOD_REGS),
    localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic [DW-1:0]     idx,
    output sel_e              sel,
    output logic [TOD_AW-1:0] tod_off,
    output logic [RAM_AW-1:0] ram_off
);
    localparam logic [DW-1:0] TOD_END = DW'(TOD_REGS);
    localparam logic [DW-1:0] RAM_LO  = DW'(RAM_BASE);
    localparam logic [DW-1:0] RAM_HI  = DW'(RAM_BASE + RAM_BYTES);

    logic [DW-1:0] ram_rel;

    always_comb begin
        ram_rel = idx - RAM_LO;
        tod_off = idx[TOD_AW-1:0];
        ram_off = ram_rel[RAM_AW-1:0];
        if (idx < TOD_END)                    sel = SEL_TOD;
        else if (idx == DW'(IDX_CTL_A))       sel = SEL_CA;
        else if (idx == DW'(IDX_CTL_B))       sel = SEL_CB;
        else if (idx == DW'(IDX_STAT_C))      sel = SEL_SC;
        else if (idx == DW'(IDX_STAT_D))      sel = SEL_SD;
        else if (idx >= RAM_LO && idx < RAM_HI) sel = SEL_RAM;
        else                                  sel = SEL_NONE;
    end
endmodule

// File: rtl/rtcr_alarm_match.sv
module rtcr_alarm_match
    import rtcr_pkg::*;
#(
    parameter int DW     = 8,
    parameter int FIELDS = 3
) (
    input  logic [FIELDS-1:0][DW-1:0] now_v,
    input  logic [FIELDS-1:0][DW-1:0] alm_v,
    output logic                      hit
);
    logic [FIELDS-1:0] fld_ok;

    for (genvar g = 0; g < FIELDS; g++) begin : g_fld
        always_comb begin
            fld_ok[g] = (alm_v[g][DW-1:DW-2] == ALARM_ANY) ||
                        (alm_v[g] == now_v[g]);
        end
    end

    assign hit = &fld_ok;
endmodule

// File: rtl/rtcr_irq_flags.sv
module rtcr_irq_flags
    import rtcr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_FLG-1:0] set_vec,
    input  logic               clr,
    input  logic [NUM_FLG-1:0] en,
    output logic [NUM_FLG-1:0] flags,
    output logic               pend
);
    typedef struct packed {
        logic [NUM_FLG-1:0] flg;
    } flg_state_t;

    flg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_FLG; i++) begin
            // clear on read, but an event in the same cycle survives
            st_d.flg[i] = (st_q.flg[i] & ~clr) | set_vec[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flg;
    assign pend  = |(st_q.flg & en);
endmodule

// File: rtl/rtcr_host_regs.sv
module rtcr_host_regs
    import rtcr_pkg::*;
#(
    parameter int DW        = 8,
    parameter int TOD_REGS  = 10,
    parameter int RAM_BASE  = 14,
    parameter int RAM_BYTES = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_addr_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          upd_done_evt,
    input  logic          periodic_evt,
    input  logic          upd_busy,
    output logic          irq_n
);
    localparam int TOD_AW  = $clog2(TOD_REGS);
    localparam int RAM_AW  = $clog2(RAM_BYTES);
    localparam int EN_LSB  = 4;
    localparam int ALM_FLD = 3;

    typedef struct packed {
        logic [DW-1:0]                idx;
        logic [DW-2:0]                ctl_a;
        logic [DW-1:0]                ctl_b;
        logic                         valid;
        logic [TOD_REGS-1:0][DW-1:0]  tod;
        logic [RAM_BYTES-1:0][DW-1:0] ram;
    } hregs_t;

    hregs_t st_d, st_q;

    sel_e              sel;
    logic [TOD_AW-1:0] tod_off;
    logic [RAM_AW-1:0] ram_off;
    logic              alarm_hit;
    logic [NUM_FLG-1:0] flag_vec;
    logic [NUM_FLG-1:0] set_vec;
    logic [NUM_FLG-1:0] ien;
    logic              pend;
    logic              clr_c;
    logic              data_wr;
    logic              data_rd;
    logic [DW-1:0]     cur_idx;
    logic [ALM_FLD-1:0][DW-1:0] now_v;
    logic [ALM_FLD-1:0][DW-1:0] alm_v;

    rtcr_index_decode #(
        .DW(DW), .TOD_REGS(TOD_REGS), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES)
    ) dec_i (
        .idx(st_q.idx), .sel(sel), .tod_off(tod_off), .ram_off(ram_off)
    );

    always_comb begin
        now_v[0] = st_q.tod[TOD_SEC];
        now_v[1] = st_q.tod[TOD_MIN];
        now_v[2] = st_q.tod[TOD_HR];
        alm_v[0] = st_q.tod[TOD_ASEC];
        alm_v[1] = st_q.tod[TOD_AMIN];
        alm_v[2] = st_q.tod[TOD_AHR];
    end

    rtcr_alarm_match #(.DW(DW), .FIELDS(ALM_FLD)) alm_i (
        .now_v(now_v), .alm_v(alm_v), .hit(alarm_hit)
    );

    assign data_wr = bus_wr && !bus_addr_sel;
    assign data_rd = bus_rd && !bus_addr_sel;
    assign clr_c   = data_rd && (sel == SEL_SC);
    assign ien     = st_q.ctl_b[EN_LSB +: NUM_FLG];
    assign cur_idx = st_q.idx;

    always_comb begin
        set_vec          = '0;
        set_vec[FLG_UPD] = upd_done_evt;
        set_vec[FLG_ALM] = upd_done_evt && alarm_hit;
        set_vec[FLG_PER] = periodic_evt;
    end

    rtcr_irq_flags flags_i (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(clr_c),
        .en(ien), .flags(flag_vec), .pend(pend)
    );

    // next-state
    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr_sel) begin
            st_d.idx = bus_wdata;
        end
        if (data_wr) begin
            unique case (sel)
                SEL_TOD: st_d.tod[tod_off] = bus_wdata;
                SEL_CA:  st_d.ctl_a        = bus_wdata[DW-2:0];
                SEL_CB:  st_d.ctl_b        = bus_wdata;
                SEL_RAM: st_d.ram[ram_off] = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.valid <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        unique case (sel)
            SEL_TOD: bus_rdata = st_q.tod[tod_off];
            SEL_CA:  bus_rdata = {upd_busy, st_q.ctl_a};
            SEL_CB:  bus_rdata = st_q.ctl_b;
            SEL_SC:  bus_rdata = {pend, flag_vec, {(DW-1-NUM_FLG){1'b0}}};
            SEL_SD:  bus_rdata = {st_q.valid, {(DW-1){1'b0}}};
            SEL_RAM: bus_rdata = st_q.ram[ram_off];
            default: bus_rdata = '0;
        endcase
    end

    assign irq_n = ~pend;
endmodule

// File: rtl/rtcr_host_regs_chk.sv
module rtcr_host_regs_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_addr_sel,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic          upd_done_evt,
    input logic          periodic_evt,
    input logic          irq_n,
    input logic          clr_c,
    input logic [2:0]    flag_vec,
    input logic [2:0]    ien,
    input logic [DW-1:0] cur_idx
);
    a_r1_index_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr_sel) |=> (cur_idx == $past(bus_wdata)));

    a_r1_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr_sel) |=> $stable(cur_idx));

    a_r5_update_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done_evt |=> flag_vec[0]);

    a_r5_tick_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_evt |=> flag_vec[2]);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_c && !upd_done_evt && !periodic_evt) |=> (flag_vec == 3'b000));

    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_c && !upd_done_evt && !periodic_evt) |=> $stable(flag_vec));

    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 3'b000) |-> irq_n);
endmodule

bind rtcr_host_regs rtcr_host_regs_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr_sel(bus_addr_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .upd_done_evt(upd_done_evt),
    .periodic_evt(periodic_evt), .irq_n(irq_n), .clr_c(clr_c),
    .flag_vec(flag_vec), .ien(ien), .cur_idx(cur_idx)
);

// File: tb/rtcr_host_regs_tb.sv
module rtcr_host_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       upd_done_evt = 1'b0;
    logic       periodic_evt = 1'b0;
    logic       upd_busy = 1'b0;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m_idx;
    logic [6:0] m_a;
    logic [7:0] m_b;
    logic [2:0] m_flg;
    logic [7:0] m_tod [10];
    logic [7:0] m_ram [50];

    always #2 clk = ~clk;

    rtcr_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr_sel(bus_addr_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_done_evt(upd_done_evt), .periodic_evt(periodic_evt),
        .upd_busy(upd_busy), .irq_n(irq_n)
    );

    function automatic bit fld_ok(input logic [7:0] now_b, input logic [7:0] alm_b);
        return (alm_b[7:6] == 2'b11) || (alm_b == now_b);
    endfunction

    function automatic bit m_alarm();
        return fld_ok(m_tod[0], m_tod[1]) && fld_ok(m_tod[2], m_tod[3]) &&
               fld_ok(m_tod[4], m_tod[5]);
    endfunction

    function automatic bit m_pend();
        return |(m_flg & m_b[6:4]);
    endfunction

    function automatic logic [7:0] m_read(input bit busy);
        if (m_idx < 8'd10)                       return m_tod[m_idx];
        if (m_idx == 8'h0A)                      return {busy, m_a};
        if (m_idx == 8'h0B)                      return m_b;
        if (m_idx == 8'h0C)                      return {m_pend(), m_flg, 4'h0};
        if (m_idx == 8'h0D)                      return 8'h80;
        if (m_idx >= 8'h0E && m_idx < 8'h40)     return m_ram[m_idx - 8'h0E];
        return 8'h00;
    endfunction

    function automatic string idx_tag(input logic [7:0] i);
        if (i == 8'h0A) return "R3";
        if (i == 8'h0B) return "R4";
        if (i == 8'h0C) return "R8";
        if (i == 8'h0D) return "R9";
        return "R2";
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // one host cycle; strobes and events applied together
    task automatic op(input bit aw, input bit dw, input bit rd, input logic [7:0] d,
                      input bit ue, input bit pe, input bit busy, input string tag);
        bit hit;
        bit clr;
        @(negedge clk);
        bus_addr_sel = aw;
        bus_wr       = aw | dw;
        bus_rd       = rd;
        bus_wdata    = d;
        upd_done_evt = ue;
        periodic_evt = pe;
        upd_busy     = busy;
        #1;
        if (rd) chk((tag == "") ? idx_tag(m_idx) : tag, bus_rdata, m_read(busy));
        @(posedge clk);
        #1;
        hit = ue && m_alarm();
        clr = rd && (m_idx == 8'h0C);
        m_flg = (clr ? 3'b000 : m_flg) | {pe, hit, ue};
        if (dw) begin
            if (m_idx < 8'd10)                        m_tod[m_idx] = d;
            else if (m_idx == 8'h0A)                  m_a = d[6:0];
            else if (m_idx == 8'h0B)                  m_b = d;
            else if (m_idx >= 8'h0E && m_idx < 8'h40) m_ram[m_idx - 8'h0E] = d;
        end
        if (aw) m_idx = d;
        bus_wr = 1'b0; bus_rd = 1'b0; upd_done_evt = 1'b0; periodic_evt = 1'b0;
        chk("R7", {7'b0, irq_n}, {7'b0, ~m_pend()});
    endtask

    task automatic sel_idx(input logic [7:0] i);
        op(1'b1, 1'b0, 1'b0, i, 1'b0, 1'b0, 1'b0, "R1");
    endtask
    task automatic wr_d(input logic [7:0] d);
        op(1'b0, 1'b1, 1'b0, d, 1'b0, 1'b0, 1'b0, "R1");
    endtask
    task automatic rd_d(input string tag);
        op(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        m_idx = 8'h00; m_a = '0; m_b = '0; m_flg = '0;
        for (int i = 0; i < 10; i++) m_tod[i] = 8'h00;
        for (int i = 0; i < 50; i++) m_ram[i] = 8'h00;
        void'($urandom(32'h0000_5A17));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state
        @(negedge clk); #1;
        chk("R10", {7'b0, irq_n}, 8'h01);
        rd_d("R10");
        sel_idx(8'h0A); rd_d("R10");
        sel_idx(8'h0C); rd_d("R10");
        sel_idx(8'h0D); rd_d("R9");
        sel_idx(8'h3F); rd_d("R10");

        // R3: busy bit read-only
        sel_idx(8'h0A); wr_d(8'hFF); rd_d("R3");
        op(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, "R3");

        // R2: storage boundaries
        sel_idx(8'h3F); wr_d(8'hA5); rd_d("R2");
        sel_idx(8'h0E); wr_d(8'h3C); rd_d("R2");
        sel_idx(8'h40); wr_d(8'h55); rd_d("R2");
        sel_idx(8'hFF); wr_d(8'h66); rd_d("R2");

        // R9: C and D ignore writes
        sel_idx(8'h0C); wr_d(8'hFF); rd_d("R9");
        sel_idx(8'h0D); wr_d(8'h00); rd_d("R9");

        // R6: wildcard alarm, flags set with enables off (R5)
        sel_idx(8'h00); wr_d(8'h05);
        sel_idx(8'h01); wr_d(8'hC0);
        sel_idx(8'h02); wr_d(8'h07);
        sel_idx(8'h03); wr_d(8'h07);
        sel_idx(8'h04); wr_d(8'h09);
        sel_idx(8'h05); wr_d(8'hFF);
        sel_idx(8'h0C);
        op(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R6");
        rd_d("R6");
        rd_d("R8");

        // R6 miss: minutes differ
        sel_idx(8'h03); wr_d(8'h08); sel_idx(8'h0C);
        op(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R6");
        rd_d("R6");

        // R7 + R4: enable periodic only
        sel_idx(8'h0B); wr_d(8'h40); rd_d("R4");
        sel_idx(8'h0C);
        op(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R7");
        // R8: event during read survives
        op(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, "R8");
        rd_d("R8");
        rd_d("R8");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int unsigned k;
            logic [7:0] d;
            bit ue, pe, bz;
            k  = $urandom % 10;
            ue = ($urandom % 6) == 0;
            pe = ($urandom % 8) == 0;
            bz = $urandom % 2;
            case ($urandom % 4)
                0: d = 8'h01;
                1: d = 8'h02;
                2: d = 8'hC1;
                default: d = 8'($urandom);
            endcase
            if (k < 3) begin
                case ($urandom % 3)
                    0: d = 8'($urandom % 8'h48);
                    1: d = 8'($urandom % 6);
                    default: d = 8'h0A + 8'($urandom % 4);
                endcase
                op(1'b1, 1'b0, 1'b0, d, ue, pe, bz, "R1");
            end else if (k < 6) begin
                op(1'b0, 1'b1, 1'b0, d, ue, pe, bz, "R1");
            end else if (k < 9) begin
                op(1'b0, 1'b0, 1'b1, 8'h00, ue, pe, bz, "");
            end else begin
                op(1'b0, 1'b0, 1'b0, 8'h00, ue, pe, bz, "R5");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule